// File: doc/BRIEF.md
# Multi-channel UART interrupt collector

This block gathers interrupt requests from four UART channels and exposes them as four byte-wide, read-only global registers on a simple host register bus. Each channel presents a request flag, a 3-bit cause code and its own interrupt-enable setting. The block latches enabled requests and shows them in two ways: a summary register with one bit per channel, and a set of packed cause-code registers.

A channel's latched bit and code are cleared when the host reads one of that channel's status registers (interrupt status, line status or modem status). Each such read arrives as a per-channel strobe. Writing the summary register does not clear anything.

The block also raises a wake-up interrupt when the device leaves sleep. It does so only if every channel was asleep in the cycle before the wake event, and a mask input can suppress it. A single registered output carries the OR of all pending conditions.

Top module: `uart_irq_collector`

## Requirements
- R1: After synchronous active-low reset, all four global registers read 0x00 and `irq_out` is 0.
- R2: `reg_addr` 0 selects the summary register. In it, bit N is 1 while channel N has a latched request, and bits 7 to 4 always read 0.
- R3: `reg_addr` 1, 2 and 3 select the cause-code registers. Channel n's code sits at bits [3n+2:3n] of the 24-bit concatenation {addr3, addr2, addr1}. Channel 2 therefore spans addr1[7:6] and addr2[0], channel 3 occupies addr2[3:1], and every other bit reads 0. The code shown is the one presented in the latest cycle with an enabled request. Code 000 means no cause.
- R4: A request whose channel enable is low neither sets the summary bit nor changes the code.
- R5: A strobe on any one of a channel's three status-read inputs clears that channel's summary bit and code to 0 at the next clock. Other channels are unaffected.
- R6: If an enabled request and a clearing strobe occur in the same cycle, the request wins and the bit stays set.
- R7: A wake event raises the wake-up interrupt only if all four channel sleep inputs were 1 in the preceding cycle.
- R8: While `wake_mask` is 1, a wake event does not raise the wake-up interrupt.
- R9: A host read (`reg_rd`) of address 0 clears the wake-up interrupt. Host reads of any global register leave channel bits and codes unchanged.
- R10: `irq_out` is the OR of all latched channel bits and the wake-up interrupt, registered, so it follows them one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_req | input | 4 | Per-channel interrupt request |
| ch_en | input | 4 | Per-channel interrupt enable |
| ch_code | input | 12 | Cause codes, channel n at [3n+2:3n] |
| ch_isr_rd | input | 4 | Per-channel interrupt-status read strobe |
| ch_lsr_rd | input | 4 | Per-channel line-status read strobe |
| ch_msr_rd | input | 4 | Per-channel modem-status read strobe |
| ch_sleep | input | 4 | Per-channel sleep state |
| wake_event | input | 1 | Device-woke pulse |
| wake_mask | input | 1 | 1 suppresses the wake-up interrupt |
| reg_rd | input | 1 | Host read strobe for the global registers |
| reg_addr | input | 2 | Global register select |
| reg_rdata | output | 8 | Read data (combinational from the address) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench drives four distinct codes at once (5, 3, 6, 7) so that any mis-packing of the straddling channel 2 or the shifted channel 3 shows up as a wrong byte. Single-channel requests separate per-channel placement from the OR into `irq_out`. Each of the three strobe types is used on a different channel, which distinguishes a correct clear from one that misses a strobe type or hits the wrong channel. Disabled requests, a request held during its clearing strobe, and wake events with all, some or masked sleep inputs separate the gating rules from the plain latching path.

// File: rtl/uirq_pkg.sv
// Package: shared sizing for the UART interrupt collector.
// Assumes a byte-wide host bus and 3-bit cause codes.
package uirq_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CAUSE_W  = 3;
    localparam logic [CAUSE_W-1:0] NO_CAUSE = '0;
endpackage

// File: rtl/uirq_channel.sv
// uirq_channel: latches one channel's enabled request and cause code.
// Assumes: request is level or pulse; any status-read strobe clears the
// latch unless an enabled request is present in the same cycle.
module uirq_channel
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               en,
    input  logic [CAUSE_W-1:0] code_in,
    input  logic               isr_rd,
    input  logic               lsr_rd,
    input  logic               msr_rd,
    output logic               pend,
    output logic [CAUSE_W-1:0] code_q
);
    logic take;
    logic drop;

    assign take = req & en;
    assign drop = isr_rd | lsr_rd | msr_rd;

    // Latch request and cause; new request wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            code_q <= NO_CAUSE;
        end else if (take) begin
            pend   <= 1'b1;
            code_q <= code_in;
        end else if (drop) begin
            pend   <= 1'b0;
            code_q <= NO_CAUSE;
        end
    end

    // R4
    disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pend) |=> !pend);
    // R6
    request_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && en && drop) |=> pend);
    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !(req && en)) |=> (!pend && code_q == NO_CAUSE));
    // R3
    code_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && en) |=> (code_q == $past(code_in)));
endmodule

// File: rtl/uirq_wake.sv
// uirq_wake: wake-up interrupt flag.
// Assumes: wake_event is a pulse; the all-asleep condition is taken from
// the cycle before the event; cleared by a host read of the summary register.
module uirq_wake #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_sleep,
    input  logic              wake_event,
    input  logic              wake_mask,
    input  logic              summary_rd,
    output logic              wake_pend
);
    logic all_asleep_q;
    logic arm;

    assign arm = wake_event & all_asleep_q & ~wake_mask;

    // Remember whether every channel was asleep last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) all_asleep_q <= 1'b0;
        else        all_asleep_q <= &ch_sleep;
    end

    // Hold the wake flag until the summary register is read.
    always_ff @(posedge clk) begin
        if (!rst_n)          wake_pend <= 1'b0;
        else if (arm)        wake_pend <= 1'b1;
        else if (summary_rd) wake_pend <= 1'b0;
    end

    // R7
    wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_asleep_q && !wake_pend) |=> !wake_pend);
    // R8
    wake_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mask && !wake_pend) |=> !wake_pend);
    // R9
    wake_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (summary_rd && !wake_event) |=> !wake_pend);
endmodule

// File: rtl/uirq_regmux.sv
// uirq_regmux: forms the summary and packed cause-code bytes and selects
// one by address. Assumes NUM_CH*CAUSE_W fits in NUM_SRC_REGS bytes.
module uirq_regmux
    import uirq_pkg::*;
#(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned NUM_SRC_REGS = 3,
    parameter int unsigned ADDR_W       = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         pend,
    input  logic [NUM_CH*CAUSE_W-1:0] codes,
    input  logic [ADDR_W-1:0]         addr,
    output logic [BYTE_W-1:0]         rdata
);
    localparam int unsigned SRC_BITS = NUM_SRC_REGS * BYTE_W;

    logic [SRC_BITS-1:0] src_pad;

    assign src_pad = SRC_BITS'(codes);

    // Select the addressed global register; unused addresses read 0.
    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata = BYTE_W'(pend);
        end else begin
            for (int i = 0; i < NUM_SRC_REGS; i++) begin
                if (int'(addr) == i + 1) rdata = src_pad[i*BYTE_W +: BYTE_W];
            end
        end
    end

    // R2
    summary_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rdata[BYTE_W-1:NUM_CH] == '0));
    // R3
    fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_CH * CAUSE_W <= SRC_BITS) || (addr == '0));
endmodule

// File: rtl/uart_irq_collector.sv
// uart_irq_collector: top of the four-channel UART interrupt collector.
// Assumes: strobes are one cycle wide and synchronous to clk; reg_rd
// qualifies reg_addr for the wake clear only.
module uart_irq_collector
    import uirq_pkg::*;
#(
    parameter int unsigned NUM_CH       = 4,
    parameter int unsigned NUM_SRC_REGS = 3,
    parameter int unsigned ADDR_W       = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         ch_req,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH*CAUSE_W-1:0] ch_code,
    input  logic [NUM_CH-1:0]         ch_isr_rd,
    input  logic [NUM_CH-1:0]         ch_lsr_rd,
    input  logic [NUM_CH-1:0]         ch_msr_rd,
    input  logic [NUM_CH-1:0]         ch_sleep,
    input  logic                      wake_event,
    input  logic                      wake_mask,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    output logic [BYTE_W-1:0]         reg_rdata,
    output logic                      irq_out
);
    logic [NUM_CH-1:0]         pend;
    logic [NUM_CH*CAUSE_W-1:0] codes;
    logic                      wake_pend;
    logic                      summary_rd;

    assign summary_rd = reg_rd & (reg_addr == '0);

    // One latch per channel.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        uirq_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (ch_req[n]),
            .en      (ch_en[n]),
            .code_in (ch_code[n*CAUSE_W +: CAUSE_W]),
            .isr_rd  (ch_isr_rd[n]),
            .lsr_rd  (ch_lsr_rd[n]),
            .msr_rd  (ch_msr_rd[n]),
            .pend    (pend[n]),
            .code_q  (codes[n*CAUSE_W +: CAUSE_W])
        );
    end

    uirq_wake #(.NUM_CH(NUM_CH)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_sleep   (ch_sleep),
        .wake_event (wake_event),
        .wake_mask  (wake_mask),
        .summary_rd (summary_rd),
        .wake_pend  (wake_pend)
    );

    uirq_regmux #(
        .NUM_CH       (NUM_CH),
        .NUM_SRC_REGS (NUM_SRC_REGS),
        .ADDR_W       (ADDR_W)
    ) u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .codes (codes),
        .addr  (reg_addr),
        .rdata (reg_rdata)
    );

    // Register the combined interrupt one clock behind the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= (|pend) | wake_pend;
    end

    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> irq_out);
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|pend) && !wake_pend) |=> !irq_out);
    // R9
    host_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !(|(ch_isr_rd | ch_lsr_rd | ch_msr_rd))) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/tb_uart_irq_collector.sv
`timescale 1ns/100ps
module tb_uart_irq_collector;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ch_req, ch_en, ch_isr_rd, ch_lsr_rd, ch_msr_rd, ch_sleep;
    logic [11:0] ch_code;
    logic        wake_event, wake_mask, reg_rd;
    logic [1:0]  reg_addr;
    logic [7:0]  reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_collector dut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en),
        .ch_code(ch_code), .ch_isr_rd(ch_isr_rd), .ch_lsr_rd(ch_lsr_rd),
        .ch_msr_rd(ch_msr_rd), .ch_sleep(ch_sleep), .wake_event(wake_event),
        .wake_mask(wake_mask), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Advance one clock; land on the falling edge for driving and sampling.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read a register combinationally, without a read strobe.
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] src_byte(input logic [2:0] c0, input logic [2:0] c1,
                                            input logic [2:0] c2, input logic [2:0] c3,
                                            input int which);
        if (which == 1) return {c2[1:0], c1, c0};
        if (which == 2) return {4'b0000, c3, c2[2]};
        return 8'h00;
    endfunction

    task automatic idle_inputs();
        ch_req = '0; ch_isr_rd = '0; ch_lsr_rd = '0; ch_msr_rd = '0;
        wake_event = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle_inputs();
        ch_en = 4'hF; ch_code = '0; ch_sleep = '0; wake_mask = 1'b0; reg_addr = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        ch_req = 4'hF; ch_code = 12'hFFF;
        rst_n = 1'b0;
        step();
        ch_req = '0;
        step();
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), d);
            chk($sformatf("R1 reg%0d after reset", a), d, 8'h00);
        end
        chk("R1 irq_out after reset", irq_out, 1'b0);
        step();
    endtask

    task automatic t_single();
        logic [7:0] d;
        ch_code = 12'h005; ch_req = 4'b0001;
        step();
        ch_req = '0;
        peek(0, d); chk("R2 summary ch0", d, 8'h01);
        peek(1, d); chk("R3 ch0 code in addr1", d, 8'h05);
        chk("R10 irq not yet", irq_out, 1'b0);
        step();
        chk("R10 irq one clock later", irq_out, 1'b1);
        ch_isr_rd = 4'b0001;
        step();
        ch_isr_rd = '0;
        peek(0, d); chk("R5 isr read clears ch0", d, 8'h00);
        peek(1, d); chk("R5 code cleared", d, 8'h00);
        step();
        chk("R10 irq drops", irq_out, 1'b0);
    endtask

    task automatic t_packing();
        logic [7:0] d;
        logic [2:0] c0 = 3'd5, c1 = 3'd3, c2 = 3'd6, c3 = 3'd7;
        ch_code = {c3, c2, c1, c0}; ch_req = 4'hF;
        step();
        ch_req = '0; ch_code = '0;
        peek(0, d); chk("R2 summary all", d, 8'h0F);
        peek(1, d); chk("R3 addr1 packing", d, src_byte(c0, c1, c2, c3, 1));
        peek(2, d); chk("R3 addr2 packing", d, src_byte(c0, c1, c2, c3, 2));
        peek(3, d); chk("R3 addr3 zero", d, 8'h00);
        // latest enabled code replaces the held one
        ch_code = 12'h000 | (12'(3'd2) << 6); ch_req = 4'b0100;
        step();
        ch_req = '0;
        peek(1, d); chk("R3 ch2 recaptured addr1", d, src_byte(c0, c1, 3'd2, c3, 1));
        peek(2, d); chk("R3 ch2 recaptured addr2", d, src_byte(c0, c1, 3'd2, c3, 2));
        // R9: host read of code registers changes nothing
        reg_rd = 1'b1; reg_addr = 2'd1;
        step();
        reg_rd = 1'b1; reg_addr = 2'd0;
        step();
        reg_rd = 1'b0;
        peek(0, d); chk("R9 host reads keep summary", d, 8'h0F);
        // R5: each strobe type on a different channel
        ch_lsr_rd = 4'b0010;
        step();
        ch_lsr_rd = '0;
        peek(0, d); chk("R5 lsr read clears ch1 only", d, 8'h0D);
        ch_msr_rd = 4'b1000;
        step();
        ch_msr_rd = '0;
        peek(0, d); chk("R5 msr read clears ch3 only", d, 8'h05);
        peek(2, d); chk("R5 ch3 code cleared", d, src_byte(3'd0, 3'd0, 3'd2, 3'd0, 2));
        ch_isr_rd = 4'b0101;
        step();
        ch_isr_rd = '0;
        peek(0, d); chk("R5 remaining cleared", d, 8'h00);
        step();
    endtask

    task automatic t_enable();
        logic [7:0] d;
        ch_en = 4'b1101; ch_code = 12'h038; ch_req = 4'b0010;
        step();
        ch_req = '0;
        peek(0, d); chk("R4 disabled request not latched", d, 8'h00);
        peek(1, d); chk("R4 disabled code not shown", d, 8'h00);
        step();
        chk("R4 irq stays low", irq_out, 1'b0);
        ch_en = 4'hF;
    endtask

    task automatic t_race();
        logic [7:0] d;
        ch_code = 12'h004; ch_req = 4'b0001;
        step();
        ch_isr_rd = 4'b0001;   // request still high in the clearing cycle
        step();
        ch_isr_rd = '0; ch_req = '0;
        peek(0, d); chk("R6 request wins over clear", d, 8'h01);
        ch_msr_rd = 4'b0001;
        step();
        ch_msr_rd = '0;
        peek(0, d); chk("R6 later clear succeeds", d, 8'h00);
        step();
    endtask

    task automatic t_wake();
        ch_sleep = 4'hF;
        step();
        wake_event = 1'b1; ch_sleep = '0;
        step();
        wake_event = 1'b0;
        chk("R7 wake not yet on irq", irq_out, 1'b0);
        step();
        chk("R7 wake raises irq", irq_out, 1'b1);
        reg_rd = 1'b1; reg_addr = 2'd2;
        step();
        reg_rd = 1'b0;
        step();
        chk("R9 read of other reg keeps wake", irq_out, 1'b1);
        reg_rd = 1'b1; reg_addr = 2'd0;
        step();
        reg_rd = 1'b0;
        step();
        chk("R9 summary read clears wake", irq_out, 1'b0);
    endtask

    task automatic t_wake_partial();
        ch_sleep = 4'b0111;
        step();
        wake_event = 1'b1;
        step();
        wake_event = 1'b0; ch_sleep = '0;
        step();
        chk("R7 no wake unless all asleep", irq_out, 1'b0);
    endtask

    task automatic t_wake_mask();
        wake_mask = 1'b1; ch_sleep = 4'hF;
        step();
        wake_event = 1'b1;
        step();
        wake_event = 1'b0; ch_sleep = '0;
        step();
        chk("R8 masked wake suppressed", irq_out, 1'b0);
        wake_mask = 1'b0;
        step();
        chk("R8 unmasking later does not raise", irq_out, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_single();
        t_packing();
        t_enable();
        t_race();
        t_wake();
        t_wake_partial();
        t_wake_mask();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule